// File: doc/BRIEF.md
# Socket FIFO Bridge for an 8-bit Host Bus

This block lets a small 8-bit processor use a set of network connections through a handful of byte-wide register addresses. The host reads an allocation register to claim a connection and receives a handle. Every byte for that connection then goes through one fixed data address per handle, so any byte value can be sent or received without escaping. Host writes to the data address queue bytes for sending. Host reads from the data address take one byte from the receive queue. A status read after each data read tells the host whether the byte it got was real. A command written to the control address releases the queued bytes to the network or closes the connection.

On the network side each connection has a transmit stream and a receive stream, each with a valid/ready handshake. The transmit stream only presents bytes that the host has committed. It marks the last byte of the committed batch so that the network engine knows where a send ends. The network stack, packet framing and the physical link lie outside this block.

Every host read returns its data on `host_rdata` one cycle after the access, and the value stays there until the next host read. Handles run from 1 to `N_SOCK`. Each queue holds `DEPTH` bytes, which must be a power of two.

Top module: `sock_bridge`

## Requirements
- R1: A host read of address 0x00 returns the lowest free handle (1..N_SOCK) and marks that handle open. When every handle is already open, the read returns 0xFF and changes nothing.
- R2: Registers for handle h live at 0x40+h (data), 0x80+h (status) and 0xC0+h (control). Read data appears on `host_rdata` in the cycle after the read and holds until the next read.
- R3: Host writes to an open handle's data address append bytes to its transmit queue in order. Those bytes are not offered on the transmit stream until they are committed.
- R4: Writing 0x01 to the control address commits every byte queued so far. Committed bytes are offered in order with `tx_valid`, and `tx_last` marks the final committed byte. `tx_last` is never high without `tx_valid`.
- R5: A host read of an open handle's data address takes the oldest received byte. It returns 0x00 when the receive queue is empty.
- R6: The status byte holds bit 0 = the most recent data read returned a real byte, bit 1 = transmit overflow, bit 2 = handle open. Bits 7..3 always read zero.
- R7: A host write to a full transmit queue is dropped and sets the overflow bit. The overflow bit stays set until the handle is closed.
- R8: For a handle that is not open, data and control writes have no effect, data and status reads return 0x00, and `rx_ready` is low.
- R9: Writing 0x02 to the control address empties both queues, clears the status and frees the handle for the next allocation read.
- R10: `rx_ready` is low while a receive queue is full. A network push and a host data read on the same handle in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| tx_valid | output | N_SOCK | Committed transmit byte available, per handle |
| tx_data | output | 8*N_SOCK | Transmit byte, per handle |
| tx_last | output | N_SOCK | Byte is the final one of the committed batch |
| tx_ready | input | N_SOCK | Network takes the transmit byte |
| rx_valid | input | N_SOCK | Network offers a received byte |
| rx_data | input | 8*N_SOCK | Received byte, per handle |
| rx_ready | output | N_SOCK | Receive queue open and not full |

## Verification
The receive queue of a handle can be written by the network and read by the host in the same cycle. The bench provokes this in two ways. In the first, one byte is waiting and a host read coincides with a new network push; the host must get the older byte, the newer byte must follow, and a further read must come back invalid. In the second, the queue is full and a push is offered while `rx_ready` is low, together with a host read. The host must drain exactly the original sixteen bytes, and the refused byte must never appear.

// File: rtl/sock_bridge.sv
module sock_bridge #(
  parameter int N_SOCK = 8,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_sel,
  input  logic                host_we,
  input  logic [7:0]          host_addr,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  output logic [N_SOCK-1:0]   tx_valid,
  output logic [8*N_SOCK-1:0] tx_data,
  output logic [N_SOCK-1:0]   tx_last,
  input  logic [N_SOCK-1:0]   tx_ready,
  input  logic [N_SOCK-1:0]   rx_valid,
  input  logic [8*N_SOCK-1:0] rx_data,
  output logic [N_SOCK-1:0]   rx_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] CMD_SEND  = 8'h01;
  localparam logic [7:0] CMD_CLOSE = 8'h02;

  wire [1:0] rgn  = host_addr[7:6];
  wire [5:0] hnum = host_addr[5:0];
  wire open_rd = host_sel && !host_we && host_addr == 8'h00;

  logic [N_SOCK-1:0] open_q, valid_q, ovf_q, rx_emp;
  logic [7:0] rx_head [N_SOCK];
  logic [7:0] free_idx, sel_head, sel_stat;
  logic       free_any, sel_open, sel_emp;

  always_comb begin
    free_any = 1'b0;
    free_idx = 8'd0;
    for (int i = N_SOCK - 1; i >= 0; i--)
      if (!open_q[i]) begin
        free_any = 1'b1;
        free_idx = 8'(i);
      end
  end

  always_comb begin
    sel_head = 8'd0;
    sel_stat = 8'd0;
    sel_open = 1'b0;
    sel_emp  = 1'b1;
    for (int i = 0; i < N_SOCK; i++)
      if (hnum == 6'(i + 1) && open_q[i]) begin
        sel_open = 1'b1;
        sel_emp  = rx_emp[i];
        sel_head = rx_head[i];
        sel_stat = {5'd0, 1'b1, ovf_q[i], valid_q[i]};
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= 8'd0;
    else if (host_sel && !host_we) begin
      case (rgn)
        2'd0:    host_rdata <= (host_addr == 8'h00) ? (free_any ? free_idx + 8'd1 : 8'hFF) : 8'd0;
        2'd1:    host_rdata <= (sel_open && !sel_emp) ? sel_head : 8'd0;
        2'd2:    host_rdata <= sel_stat;
        default: host_rdata <= 8'd0;
      endcase
    end
  end

  for (genvar g = 0; g < N_SOCK; g++) begin : g_sock
    logic [7:0]  tmem [DEPTH];
    logic [7:0]  rmem [DEPTH];
    logic [AW:0] twp, trp, tcp, rwp, rrp;

    wire hit    = host_sel && open_q[g] && hnum == 6'(g + 1);
    wire t_wr   = hit && host_we && rgn == 2'd1;
    wire r_rd   = hit && !host_we && rgn == 2'd1;
    wire ctl    = hit && host_we && rgn == 2'd3;
    wire send   = ctl && host_wdata == CMD_SEND;
    wire close  = ctl && host_wdata == CMD_CLOSE;
    wire t_full = (twp - trp) == (AW+1)'(DEPTH);
    wire r_full = (rwp - rrp) == (AW+1)'(DEPTH);
    wire t_pop  = tx_valid[g] && tx_ready[g];
    wire r_push = rx_valid[g] && rx_ready[g];
    wire r_pop  = r_rd && !rx_emp[g];

    assign tx_valid[g]          = trp != tcp;
    assign tx_last[g]           = tx_valid[g] && (AW+1)'(trp + 1'b1) == tcp;
    assign tx_data[g*8 +: 8]    = tmem[trp[AW-1:0]];
    assign rx_emp[g]            = rwp == rrp;
    assign rx_head[g]           = rmem[rrp[AW-1:0]];
    assign rx_ready[g]          = open_q[g] && !r_full;

    always_ff @(posedge clk) begin
      if (t_wr && !t_full) tmem[twp[AW-1:0]] <= host_wdata;
      if (r_push)          rmem[rwp[AW-1:0]] <= rx_data[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || close) begin
        {twp, trp, tcp, rwp, rrp} <= '0;
        open_q[g]  <= 1'b0;
        valid_q[g] <= 1'b0;
        ovf_q[g]   <= 1'b0;
      end else begin
        if (open_rd && free_any && free_idx == 8'(g)) open_q[g] <= 1'b1;
        if (t_wr && !t_full) twp <= twp + 1'b1;
        if (t_wr && t_full)  ovf_q[g] <= 1'b1;
        if (send)            tcp <= twp;
        if (t_pop)           trp <= trp + 1'b1;
        if (r_push)          rwp <= rwp + 1'b1;
        if (r_pop)           rrp <= rrp + 1'b1;
        if (r_rd)            valid_q[g] <= !rx_emp[g];
      end
    end
  end
endmodule

// File: rtl/sock_bridge_chk.sv
module sock_bridge_chk #(
  parameter int N_SOCK = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_we,
  input logic [7:0]        host_addr,
  input logic [7:0]        host_rdata,
  input logic [N_SOCK-1:0] tx_valid,
  input logic [N_SOCK-1:0] tx_last
);
  p_open_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_we && host_addr == 8'h00) |=>
      (host_rdata == 8'hFF || (host_rdata >= 8'd1 && host_rdata <= 8'(N_SOCK))));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_sel && !host_we) |=> $stable(host_rdata));

  p_last_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last & ~tx_valid) == '0);

  p_status_high_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_we && host_addr[7:6] == 2'd2) |=> host_rdata[7:3] == 5'd0);
endmodule

bind sock_bridge sock_bridge_chk #(.N_SOCK(N_SOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
  .host_addr(host_addr), .host_rdata(host_rdata),
  .tx_valid(tx_valid), .tx_last(tx_last)
);

// File: tb/sock_bridge_tb.sv
module sock_bridge_tb;
  localparam int N = 8;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_we = 1'b0;
  logic [7:0] host_addr = 8'd0, host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic [N-1:0] tx_valid, tx_last, rx_ready;
  logic [N-1:0] tx_ready = '0, rx_valid = '0;
  logic [8*N-1:0] tx_data;
  logic [8*N-1:0] rx_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sock_bridge #(.N_SOCK(N), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  // {op 1=read/0=write, addr, wdata, expected}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h00, 8'h01},  // R1 first handle
    {1'b1, 8'h00, 8'h00, 8'h02},  // R1 second handle
    {1'b1, 8'h81, 8'h00, 8'h04},  // R6 open, nothing read
    {1'b1, 8'h41, 8'h00, 8'h00},  // R5 empty read
    {1'b1, 8'h81, 8'h00, 8'h04},  // R6 invalid after empty read
    {1'b1, 8'h43, 8'h00, 8'h00},  // R8 unopened data
    {1'b1, 8'h83, 8'h00, 8'h00},  // R8 unopened status
    {1'b0, 8'h43, 8'h55, 8'h00},  // R8 write ignored
    {1'b0, 8'h41, 8'hAA, 8'h00},  // R3
    {1'b0, 8'h41, 8'hBB, 8'h00},  // R3
    {1'b0, 8'h42, 8'h11, 8'h00},  // R3
    {1'b1, 8'h81, 8'h00, 8'h04}   // R2 status address
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [7:0] d);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_sel = 1'b0;
    d = host_rdata;
  endtask

  task automatic hrd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    hrd(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic npush(input int s, input logic [7:0] d);
    rx_valid[s] = 1'b1; rx_data[s*8 +: 8] = d;
    @(negedge clk);
    rx_valid[s] = 1'b0;
  endtask

  task automatic npop(input int s, input logic [7:0] exp, input bit exp_last, input string tag);
    chk(tx_valid[s] == 1'b1, tag, tx_valid[s], 1);
    chk(tx_data[s*8 +: 8] == exp, tag, tx_data[s*8 +: 8], exp);
    chk(tx_last[s] == exp_last, tag, tx_last[s], exp_last);
    tx_ready[s] = 1'b1;
    @(negedge clk);
    tx_ready[s] = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rdata == 8'h00, "reset rdata", host_rdata, 0);
    chk(tx_valid == '0, "reset tx_valid", tx_valid, 0);
    chk(rx_ready == '0, "R8 reset rx_ready", rx_ready, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) hrd_chk(VEC[i][23:16], VEC[i][7:0], $sformatf("vector %0d", i));
      else hwr(VEC[i][23:16], VEC[i][15:8]);
    end

    chk(tx_valid[1:0] == 2'b00, "R3 uncommitted hidden", tx_valid, 0);
    chk(rx_ready[2:0] == 3'b011, "R8 rx_ready per open", rx_ready, 3);

    hwr(8'hC1, 8'h01);
    npop(0, 8'hAA, 1'b0, "R4 first");
    npop(0, 8'hBB, 1'b1, "R4 last");
    chk(tx_valid[0] == 1'b0, "R4 drained", tx_valid[0], 0);
    chk(tx_valid[2] == 1'b0, "R8 no tx unopened", tx_valid[2], 0);

    hwr(8'h41, 8'hCC);
    hwr(8'hC1, 8'h01);
    hwr(8'h41, 8'hDD);
    npop(0, 8'hCC, 1'b1, "R4 second batch");
    chk(tx_valid[0] == 1'b0, "R3 later byte waits", tx_valid[0], 0);
    hwr(8'hC1, 8'h01);
    npop(0, 8'hDD, 1'b1, "R4 third batch");

    npush(0, 8'h10);
    npush(0, 8'h20);
    hrd_chk(8'h41, 8'h10, "R5 first rx");
    hrd_chk(8'h81, 8'h05, "R6 valid");
    hrd_chk(8'h41, 8'h20, "R5 second rx");
    hrd_chk(8'h41, 8'h00, "R5 empty");
    hrd_chk(8'h81, 8'h04, "R6 invalid");

    // R10 same-cycle push and pop
    npush(0, 8'h30);
    rx_valid[0] = 1'b1; rx_data[7:0] = 8'h40;
    hrd(8'h41, d);
    rx_valid[0] = 1'b0;
    chk(d == 8'h30, "R10 concurrent older", d, 8'h30);
    hrd_chk(8'h41, 8'h40, "R10 concurrent newer");
    hrd_chk(8'h41, 8'h00, "R10 then empty");

    // R10 full queue
    for (int i = 0; i < D; i++) npush(0, 8'(8'h60 + i));
    chk(rx_ready[0] == 1'b0, "R10 full not ready", rx_ready[0], 0);
    rx_valid[0] = 1'b1; rx_data[7:0] = 8'h99;
    hrd(8'h41, d);
    rx_valid[0] = 1'b0;
    chk(d == 8'h60, "R10 pop while full", d, 8'h60);
    chk(rx_ready[0] == 1'b1, "R10 ready after pop", rx_ready[0], 1);
    for (int i = 1; i < D; i++) hrd_chk(8'h41, 8'(8'h60 + i), "R10 drain order");
    hrd_chk(8'h41, 8'h00, "R10 refused byte absent");

    // R7 overflow on handle 2 (holds 0x11 already)
    for (int i = 0; i < D - 1; i++) hwr(8'h42, 8'(8'h70 + i));
    hrd_chk(8'h82, 8'h04, "R7 full no overflow");
    hwr(8'h42, 8'hEE);
    hrd_chk(8'h82, 8'h06, "R7 overflow set");
    hwr(8'hC2, 8'h01);
    npop(1, 8'h11, 1'b0, "R3 order first");
    for (int i = 0; i < D - 1; i++) npop(1, 8'(8'h70 + i), i == D - 2, "R7 drain");
    chk(tx_valid[1] == 1'b0, "R7 dropped byte absent", tx_valid[1], 0);
    hrd_chk(8'h82, 8'h06, "R7 overflow sticky");

    for (int i = 3; i <= N; i++) hrd_chk(8'h00, 8'(i), "R1 allocate");
    hrd_chk(8'h00, 8'hFF, "R1 exhausted");

    // R9 close handle 2
    hwr(8'h42, 8'h21);
    hwr(8'hC2, 8'h01);
    npush(1, 8'h33);
    chk(tx_valid[1] == 1'b1, "R9 pre-close tx", tx_valid[1], 1);
    hwr(8'hC2, 8'h02);
    chk(tx_valid[1] == 1'b0, "R9 tx flushed", tx_valid[1], 0);
    chk(rx_ready[1] == 1'b0, "R9 rx closed", rx_ready[1], 0);
    hrd_chk(8'h82, 8'h00, "R9 status cleared");
    hwr(8'hC2, 8'h01);
    chk(tx_valid[1] == 1'b0, "R8 control on closed", tx_valid[1], 0);
    hrd_chk(8'h00, 8'h02, "R9 handle reused");
    hrd_chk(8'h82, 8'h04, "R9 overflow cleared");
    hrd_chk(8'h42, 8'h00, "R9 rx flushed");

    done = 1'b1;
    finish_run();
  end
endmodule